// File: doc/BRIEF.md
# Protected Region Matcher and Redundancy Address Generator

This block sits beside a last-level-cache bank and looks at the physical address of every line that moves between the cache and persistent memory, in both directions. Software programs up to eight region registers. Each one describes a directly-mapped range of physical pages, together with where that range's page checksums and per-line checksums are kept. For each request the block reports whether the line is protected. When it is, the block also returns the byte address of the line's page checksum, the byte address of its per-line checksum, and the address of the parity line that covers it.

Memory is spread across four modules with page striping. Physical page P lives on module P mod 4 in stripe P / 4. In stripe s, the parity page sits on module 3 - (s mod 4). Each checksum is 4 bytes wide, so one line holds 16 of them. Page checksums are kept in the same module as the page they cover. Lines that match no region, and lines of parity pages, get no redundancy action. The block has a two-stage pipeline that accepts one request per clock.

Top module: `prot_region_map`

## Requirements
- R1: While `rst` is high, `req_ready` and `res_valid` are 0. After reset, `req_ready` is 1 and every region is invalid.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. Its result appears on the outputs after the following rising edge, with `res_valid` high for exactly one cycle. Back-to-back requests produce results in acceptance order, one per cycle, and `res_valid` never rises without an accepted request.
- R3: Let P be address bits [39:12]. `res_hit` is 1 only when some valid region satisfies base <= P < base + count. When `res_hit` is 0, all three address outputs are zero.
- R4: When several valid regions contain P, the lowest-numbered one supplies the result. Invalid regions are skipped.
- R5: Let m = P mod 4 and s = P / 4. When m equals 3 - (s mod 4), the line belongs to a parity page and `res_hit` is 0.
- R6: `res_par_addr` = ((4*s + 3 - (s mod 4)) << 12) + (line << 6), where line is address bits [11:6].
- R7: Let q = s - (base / 4), and let C be the region's checksum stripe. `res_pcs_addr` = ((((C + q/1024) mod 2^26) * 4 + m) << 12) + (q mod 1024) * 4. The page checksum is therefore on module m, and 16 consecutive stripes of one module share a line.
- R8: `res_lcs_addr` = (L with bits [5:0] cleared) + ((P - base) * 64 + line) * 4, taken mod 2^40, where L is the region's line-checksum base. Bits [5:2] of the result give the 4-byte slot within its line.
- R9: A region write replaces all fields of one region at once. A write on the same edge as an acceptance, or after it, does not change that request's result; requests accepted later see the new value. Writing the valid field as 0 removes the region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Region register write strobe |
| wr_idx | input | 3 | Region number to write |
| wr_valid | input | 1 | Valid bit to write |
| wr_base | input | 28 | First physical page of the region |
| wr_npages | input | 20 | Number of pages in the region |
| wr_pcs_stripe | input | 26 | Stripe number where the region's page-checksum area starts |
| wr_lcs_base | input | 40 | Byte address of the per-line checksum buffer (bits [5:0] ignored) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 40 | Physical byte address of the line |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | Line is protected |
| res_pcs_addr | output | 40 | Byte address of the page checksum |
| res_lcs_addr | output | 40 | Byte address of the per-line checksum |
| res_par_addr | output | 40 | Byte address of the covering parity line |

## Verification
The assertions compare each result with the request address sampled two edges earlier. They therefore assume the input address is meaningful on every accepted edge. They also assume software places a region's checksum area correctly, so the module field of the page-checksum address must match the data page. The stimulus drives every request, and its region writes, at the falling edge. It keeps `req_valid` low between deliberate requests. It programs regions whose page counts fit inside the address space, so a region never wraps past the top page.

// File: rtl/prot_region_map.sv
module prot_region_map #(
  parameter int ADDR_W = 40,
  parameter int PAGE_W = 12,
  parameter int LINE_W = 6,
  parameter int MOD_W  = 2,
  parameter int NREG   = 8,
  parameter int NPG_W  = 20
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [$clog2(NREG)-1:0]          wr_idx,
  input  logic                             wr_valid,
  input  logic [ADDR_W-PAGE_W-1:0]         wr_base,
  input  logic [NPG_W-1:0]                 wr_npages,
  input  logic [ADDR_W-PAGE_W-MOD_W-1:0]   wr_pcs_stripe,
  input  logic [ADDR_W-1:0]                wr_lcs_base,
  input  logic                             req_valid,
  output logic                             req_ready,
  input  logic [ADDR_W-1:0]                req_addr,
  output logic                             res_valid,
  output logic                             res_hit,
  output logic [ADDR_W-1:0]                res_pcs_addr,
  output logic [ADDR_W-1:0]                res_lcs_addr,
  output logic [ADDR_W-1:0]                res_par_addr
);
  localparam int PPN_W  = ADDR_W - PAGE_W;
  localparam int ST_W   = PPN_W - MOD_W;
  localparam int IDX_W  = $clog2(NREG);
  localparam int LI_W   = PAGE_W - LINE_W;
  localparam int SLOT_W = PAGE_W - 2;

  logic [NREG-1:0]  rv;
  logic [PPN_W-1:0] rbase [NREG];
  logic [NPG_W-1:0] rnp   [NREG];
  logic [ST_W-1:0]  rcs   [NREG];
  logic [ADDR_W-1:0] rlb  [NREG];

  assign req_ready = !rst;
  wire accept = req_valid && req_ready;

  // region registers
  always_ff @(posedge clk) begin
    if (rst) rv <= '0;
    else if (wr_en) begin
      rv[wr_idx]    <= wr_valid;
      rbase[wr_idx] <= wr_base;
      rnp[wr_idx]   <= wr_npages;
      rcs[wr_idx]   <= wr_pcs_stripe;
      rlb[wr_idx]   <= wr_lcs_base;
    end
  end

  // stage A: range match and priority pick
  wire [PPN_W-1:0] in_page = req_addr[ADDR_W-1:PAGE_W];
  wire             in_par  = in_page[MOD_W-1:0] == ~in_page[2*MOD_W-1:MOD_W];
  logic [NREG-1:0] match;

  for (genvar i = 0; i < NREG; i++) begin : g_cmp
    wire [PPN_W-1:0] off = in_page - rbase[i];
    assign match[i] = rv[i] && (in_page >= rbase[i]) &&
                      (off < {{(PPN_W-NPG_W){1'b0}}, rnp[i]});
  end

  logic [IDX_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = NREG-1; i >= 0; i--)
      if (match[i]) sel = IDX_W'(i);
  end

  logic              a_v, a_hit;
  logic [ADDR_W-1:0] a_addr, a_lb;
  logic [PPN_W-1:0]  a_base;
  logic [ST_W-1:0]   a_cs;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_v <= 1'b0; a_hit <= 1'b0; a_addr <= '0;
      a_base <= '0; a_cs <= '0; a_lb <= '0;
    end else begin
      a_v    <= accept;
      a_hit  <= accept && (|match) && !in_par;
      a_addr <= req_addr;
      a_base <= rbase[sel];
      a_cs   <= rcs[sel];
      a_lb   <= rlb[sel];
    end
  end

  // stage B: address generation
  wire [PPN_W-1:0] pg   = a_addr[ADDR_W-1:PAGE_W];
  wire [LI_W-1:0]  li   = a_addr[PAGE_W-1:LINE_W];
  wire [ST_W-1:0]  st   = pg[PPN_W-1:MOD_W];
  wire [MOD_W-1:0] md   = pg[MOD_W-1:0];
  wire [ST_W-1:0]  q    = st - a_base[PPN_W-1:MOD_W];
  wire [ST_W-1:0]  cpg  = a_cs + (q >> SLOT_W);
  wire [PPN_W-1:0] rel  = pg - a_base;
  wire [ADDR_W-1:0] lofs = ADDR_W'({rel, li, 2'b00});

  wire [ADDR_W-1:0] pcs_n = {cpg, md, q[SLOT_W-1:0], 2'b00};
  wire [ADDR_W-1:0] lcs_n = {a_lb[ADDR_W-1:LINE_W], {LINE_W{1'b0}}} + lofs;
  wire [ADDR_W-1:0] par_n = {st, ~st[MOD_W-1:0], li, {LINE_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0; res_hit <= 1'b0;
      res_pcs_addr <= '0; res_lcs_addr <= '0; res_par_addr <= '0;
    end else begin
      res_valid    <= a_v;
      res_hit      <= a_hit;
      res_pcs_addr <= a_hit ? pcs_n : '0;
      res_lcs_addr <= a_hit ? lcs_n : '0;
      res_par_addr <= a_hit ? par_n : '0;
    end
  end

  a_r2_result_follows_accept: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(req_valid && req_ready, 2));
  a_r2_accept_gives_result: assert property (@(posedge clk) disable iff (rst)
    $past(req_valid && req_ready, 2) && !$past(rst, 1) && !$past(rst, 2) |-> res_valid);
  a_r2_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> res_valid);
  a_r3_miss_zero: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_hit |-> res_pcs_addr == '0 && res_lcs_addr == '0 && res_par_addr == '0);
  a_r5_parity_page_miss: assert property (@(posedge clk) disable iff (rst)
    res_valid && ($past(req_addr[PAGE_W +: MOD_W], 2) == ~$past(req_addr[PAGE_W+MOD_W +: MOD_W], 2))
    |-> !res_hit);
  a_r6_parity_other_module: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> res_par_addr[PAGE_W +: MOD_W] != $past(req_addr[PAGE_W +: MOD_W], 2));
  a_r6_parity_same_line: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> res_par_addr[LINE_W +: LI_W] == $past(req_addr[LINE_W +: LI_W], 2));
  a_r7_pcs_same_module: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> res_pcs_addr[PAGE_W +: MOD_W] == $past(req_addr[PAGE_W +: MOD_W], 2));
  a_r8_lcs_slot: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> res_lcs_addr[2 +: LINE_W-2] == $past(req_addr[LINE_W +: LINE_W-2], 2));
endmodule

// File: tb/sim_prot_region_map.sv
module sim_prot_region_map;
  localparam int NR = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        wr_en = 0, wr_valid = 0, req_valid = 0;
  logic [2:0]  wr_idx = 0;
  logic [27:0] wr_base = 0;
  logic [19:0] wr_npages = 0;
  logic [25:0] wr_pcs_stripe = 0;
  logic [39:0] wr_lcs_base = 0, req_addr = 0;
  logic        req_ready, res_valid, res_hit;
  logic [39:0] res_pcs_addr, res_lcs_addr, res_par_addr;

  prot_region_map u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_base(wr_base), .wr_npages(wr_npages), .wr_pcs_stripe(wr_pcs_stripe),
    .wr_lcs_base(wr_lcs_base), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .res_valid(res_valid), .res_hit(res_hit),
    .res_pcs_addr(res_pcs_addr), .res_lcs_addr(res_lcs_addr), .res_par_addr(res_par_addr));

  typedef struct packed {
    logic hit;
    logic [39:0] pcs, lcs, par;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  bit          mv[NR];
  logic [63:0] mb[NR], mn[NR], mc[NR], ml[NR];
  int checks = 0, fails = 0;
  bit done = 0;
  exp_t  mon_e;
  string mon_t;

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [39:0] pa(logic [63:0] page, logic [63:0] line);
    return 40'((page << 12) | (line << 6));
  endfunction

  function automatic exp_t model(logic [39:0] a);
    logic [63:0] p, s, m, li, q;
    exp_t e;
    e = '0;
    p = 64'(a) >> 12; li = (64'(a) >> 6) & 63; s = p >> 2; m = p & 3;
    if (m == 3 - (s & 3)) return e;
    for (int i = 0; i < NR; i++) begin
      if (mv[i] && p >= mb[i] && p < mb[i] + mn[i]) begin
        q = s - (mb[i] >> 2);
        e.hit = 1'b1;
        e.pcs = 40'((((mc[i] + (q >> 10)) * 4 + m) * 4096) + (q & 1023) * 4);
        e.lcs = 40'((ml[i] & ~64'h3f) + ((p - mb[i]) * 64 + li) * 4);
        e.par = 40'((s * 4 + 3 - (s & 3)) * 4096 + li * 64);
        return e;
      end
    end
    return e;
  endfunction

  task automatic set_wr(int i, bit v, logic [63:0] b, logic [63:0] n, logic [63:0] c, logic [63:0] l);
    wr_en = 1; wr_idx = 3'(i); wr_valid = v; wr_base = 28'(b);
    wr_npages = 20'(n); wr_pcs_stripe = 26'(c); wr_lcs_base = 40'(l);
    mv[i] = v; mb[i] = b; mn[i] = n; mc[i] = c; ml[i] = l;
  endtask

  task automatic wr(int i, bit v, logic [63:0] b, logic [63:0] n, logic [63:0] c, logic [63:0] l);
    set_wr(i, v, b, n, c, l);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic send(logic [39:0] a, string t);
    req_valid = 1; req_addr = a;
    expq.push_back(model(a)); tagq.push_back(t);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic send_wr(logic [39:0] a, string t, int i, bit v, logic [63:0] b,
                         logic [63:0] n, logic [63:0] c, logic [63:0] l);
    req_valid = 1; req_addr = a;
    expq.push_back(model(a)); tagq.push_back(t);
    set_wr(i, v, b, n, c, l);
    @(negedge clk);
    req_valid = 0; wr_en = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !done && res_valid) begin
      if (expq.size() == 0) chk(0, "R2", "unexpected res_valid", 1, 0);
      else begin
        mon_e = expq.pop_front();
        mon_t = tagq.pop_front();
        chk(res_hit == mon_e.hit, mon_t, "hit", 64'(res_hit), 64'(mon_e.hit));
        chk(res_pcs_addr == mon_e.pcs, mon_t, "pcs(R7)", 64'(res_pcs_addr), 64'(mon_e.pcs));
        chk(res_lcs_addr == mon_e.lcs, mon_t, "lcs(R8)", 64'(res_lcs_addr), 64'(mon_e.lcs));
        chk(res_par_addr == mon_e.par, mon_t, "par(R6)", 64'(res_par_addr), 64'(mon_e.par));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R2 watchdog actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) begin mv[i] = 0; mb[i] = 0; mn[i] = 0; mc[i] = 0; ml[i] = 0; end
    repeat (3) @(negedge clk);
    chk(req_ready == 0, "R1", "ready in reset", 64'(req_ready), 0);
    chk(res_valid == 0, "R1", "valid in reset", 64'(res_valid), 0);
    rst = 0;
    @(negedge clk);
    chk(req_ready == 1, "R1", "ready after reset", 64'(req_ready), 1);
    chk(res_valid == 0, "R1", "valid after reset", 64'(res_valid), 0);

    // R1: all regions invalid after reset
    send(pa(100, 3), "R1");
    send(pa(5, 0), "R1");

    // R2: latency of exactly two edges
    repeat (3) @(negedge clk);
    req_valid = 1; req_addr = pa(7, 1);
    expq.push_back(model(pa(7, 1))); tagq.push_back("R2");
    @(negedge clk);
    req_valid = 0;
    chk(res_valid == 0, "R2", "valid one edge after accept", 64'(res_valid), 0);
    @(negedge clk);
    chk(res_valid == 1, "R2", "valid two edges after accept", 64'(res_valid), 1);
    @(negedge clk);
    chk(res_valid == 0, "R2", "valid single cycle", 64'(res_valid), 0);

    // R3/R8: region 0 with low bits set in line-checksum base
    wr(0, 1, 100, 40, 5000, 64'h12_3456_7811);
    send(pa(100, 0), "R3");
    send(pa(139, 63), "R3");
    send(pa(140, 0), "R3");
    send(pa(98, 63), "R3");
    send(40'(pa(101, 9) | 40'h2a), "R8");
    send(pa(120, 17), "R6");
    send(pa(113, 31), "R7");

    // R5: parity pages inside the region
    send(pa(102, 5), "R5");
    send(pa(105, 0), "R5");

    // R2: back-to-back burst
    for (int j = 0; j < 20; j++) send(pa(100 + j, (j * 7) % 64), "R2");

    // R4: overlapping regions, invalid lower one ignored
    wr(1, 0, 1000, 200, 1234, 64'h10_0000_0000);
    wr(2, 1, 1000, 100, 7000, 64'h40_0000_0000);
    wr(5, 1, 1050, 100, 9000, 64'h50_0000_0000);
    send(pa(1060, 2), "R4");
    send(pa(1120, 40), "R4");
    send(pa(1000, 0), "R4");
    send(pa(1149, 63), "R4");

    // R7 and R8: wrap-around of checksum areas
    wr(3, 1, 0, 8192, 26'h3FF_FFFF, 64'hFF_FFFF_FFC0);
    send(pa(4200, 10), "R7");
    send(pa(4092, 63), "R7");
    send(pa(8000, 62), "R8");
    send(pa(8192, 0), "R3");

    // R9: write in the same cycle as an accept is not seen
    send_wr(pa(120, 1), "R9", 0, 1, 100, 40, 6000, 64'h20_0000_0000);
    send(pa(120, 1), "R9");
    wr(0, 0, 100, 40, 6000, 64'h20_0000_0000);
    send(pa(120, 1), "R9");
    wr(3, 0, 0, 0, 0, 0);
    send(pa(120, 1), "R9");

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R2", "results outstanding", 64'(expq.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule